// File: doc/BRIEF.md
# Parallel Display Bus Write Engine

This block is the host-side master that writes to a display controller over a parallel bus. It takes one write request at a time. A request carries three things: a select that marks it as a command or as data, a select that marks it as a register word or a pixel-memory word, and a value of up to 18 bits. The engine frames the request with chip select and the command/data line. It cuts the value into one, two or three bus beats and latches each beat with a strobe. The beat layout depends on the bus width chosen at run time (8, 9, 16 or 18 lines) and on the pixel colour depth (16-bit or 18-bit).

Two strobe styles are supported. In the write-strobe style, each beat gets one low pulse on a write-enable line. In the enable style, a read/write line is held at write and each beat gets one high pulse on an enable line. Three parameters set the timing, each in clock cycles: the data setup before the strobe, the strobe-active width and the strobe-inactive recovery. The mode inputs are sampled when the request is accepted, so one transaction always uses a single layout. A one-cycle completion pulse marks the end of the transaction.

Top module: `pdw_write_engine`

## Requirements
- R1: While reset is high, and after it is released with no request pending, the engine is ready, chip select is high, the write strobe is high, the enable strobe is low, read/write is high, the command/data line is low, the data bus is all zero and done is low.
- R2: A request is taken only in a cycle where req_valid and req_ready are both high. req_ready stays low from that cycle until the cycle after done. Anything on the request and mode inputs while the engine is busy has no effect on the transaction under way, and starts no extra transaction.
- R3: Chip select goes low one cycle before the first beat's setup phase and stays low through the recovery phase of the last beat. The command/data line is 0 for a command and 1 for data, and it holds that value through every beat. Done is high for exactly one cycle, the first cycle in which chip select is high again.
- R4: Each beat drives its data for SETUP_CYC cycles with the strobe inactive, then holds the strobe active for LOW_CYC cycles, then keeps it inactive for HIGH_CYC cycles. The data does not change while the strobe is active. Chip select is low for 1 + beats x (SETUP_CYC + LOW_CYC + HIGH_CYC) cycles.
- R5: With cfg_bus6800 = 0, each beat is one low pulse on bus_wr_n, and bus_e stays low. With cfg_bus6800 = 1, bus_wr_n stays high, bus_rw is 0 while chip select is low, and each beat is one high pulse on bus_e.
- R6: Pixel layout applies only when both req_is_data and req_is_pixel are 1. Every other request is a register word, taken from value[15:0]. With cfg_width = 0 (8 lines), a register word, or a pixel at cfg_depth18 = 0, takes two beats on bus_data[17:10]: value[15:8] first, then value[7:0].
- R7: With cfg_width = 0 and cfg_depth18 = 1, a pixel takes three beats on bus_data[17:12]: value[17:12], then value[11:6], then value[5:0].
- R8: With cfg_width = 1 (9 lines), a register word takes two beats on bus_data[17:10], high byte first. A pixel, at either depth, takes two beats on bus_data[17:9]: value[17:9] first, then value[8:0].
- R9: With cfg_width = 2 (16 lines), a register word, or a pixel at cfg_depth18 = 0, is one beat: value[15:8] on bus_data[17:10] and value[7:0] on bus_data[8:1].
- R10: With cfg_width = 2 and cfg_depth18 = 1, a pixel takes three beats: value[17:12] on bus_data[17:12], then value[11:6] on bus_data[8:3], then value[5:0] on bus_data[17:12].
- R11: With cfg_width = 3 (18 lines), a register word uses the same single-beat layout as R9. A pixel, at either depth, is one beat with value[17:0] on bus_data[17:0].
- R12: Every data line that a beat does not use is 0. While chip select is high, the whole data bus is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The engine is idle and takes a request |
| req_is_data | input | 1 | 0 = command, 1 = data |
| req_is_pixel | input | 1 | 1 = pixel-memory word, 0 = register word |
| req_value | input | 18 | Value to write |
| cfg_width | input | 2 | Bus width: 0 = 8, 1 = 9, 2 = 16, 3 = 18 lines |
| cfg_depth18 | input | 1 | 1 = 18-bit pixels, 0 = 16-bit pixels |
| cfg_bus6800 | input | 1 | 1 = enable-strobe style, 0 = write-strobe style |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Command/data line |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_e | output | 1 | Enable strobe, active high |
| bus_rw | output | 1 | Read/write line, 0 = write |
| bus_data | output | 18 | Data lines D17..D0 |
| done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
The completion pulse and an offer of a new request can fall in the same cycle. The bench provokes this by keeping req_valid high through the whole transaction, with every request and mode field inverted, up to and including the done cycle. The bench judges the result in three ways. req_ready must be low in the done cycle. The scoreboard must see no beat it did not expect, and every beat must carry the original value and command/data level. The measured chip-select low time must equal the length computed for the original request.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    localparam int DATA_W    = 18;
    localparam int REG_W     = 16;
    localparam int MAX_BEATS = 3;
    localparam int BEAT_IW   = $clog2(MAX_BEATS + 1);

    typedef enum logic [1:0] {
        BUS_W8  = 2'd0,
        BUS_W9  = 2'd1,
        BUS_W16 = 2'd2,
        BUS_W18 = 2'd3
    } bus_width_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              is_data;
        logic              is_pixel;
        logic [DATA_W-1:0] value;
        bus_width_e        width;
        logic              depth18;
        logic              bus6800;
    } wr_req_t;

    typedef struct packed {
        logic [BEAT_IW-1:0]                count;
        logic [MAX_BEATS-1:0][DATA_W-1:0]  word;
    } beat_plan_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Byte on the upper eight lines
    function automatic logic [DATA_W-1:0] on_hi8(input logic [7:0] x);
        return {x, 10'b0};
    endfunction

    // Nine bits on the upper nine lines
    function automatic logic [DATA_W-1:0] on_hi9(input logic [8:0] x);
        return {x, 9'b0};
    endfunction

    // Six bits on the upper six lines
    function automatic logic [DATA_W-1:0] on_hi6(input logic [5:0] x);
        return {x, 12'b0};
    endfunction

    // Six bits on lines 8..3
    function automatic logic [DATA_W-1:0] on_mid6(input logic [5:0] x);
        return {9'b0, x, 3'b0};
    endfunction

    // Sixteen bits on lines 17..10 and 8..1, skipping 9 and 0
    function automatic logic [DATA_W-1:0] spread16(input logic [REG_W-1:0] x);
        return {x[15:8], 1'b0, x[7:0], 1'b0};
    endfunction

endpackage

// File: rtl/pdw_beat_planner.sv
module pdw_beat_planner
    import pdw_pkg::*;
(
    input  logic              pix,
    input  bus_width_e        width,
    input  logic              depth18,
    input  logic [DATA_W-1:0] value,
    output beat_plan_t        plan
);

    logic [REG_W-1:0] reg_word;
    assign reg_word = value[REG_W-1:0];

    always_comb begin
        plan = '0;
        unique case (width)
            BUS_W8: begin
                if (pix && depth18) begin
                    plan.count   = BEAT_IW'(3);
                    plan.word[0] = on_hi6(value[17:12]);
                    plan.word[1] = on_hi6(value[11:6]);
                    plan.word[2] = on_hi6(value[5:0]);
                end else begin
                    plan.count   = BEAT_IW'(2);
                    plan.word[0] = on_hi8(reg_word[15:8]);
                    plan.word[1] = on_hi8(reg_word[7:0]);
                end
            end
            BUS_W9: begin
                plan.count = BEAT_IW'(2);
                if (pix) begin
                    plan.word[0] = on_hi9(value[17:9]);
                    plan.word[1] = on_hi9(value[8:0]);
                end else begin
                    plan.word[0] = on_hi8(reg_word[15:8]);
                    plan.word[1] = on_hi8(reg_word[7:0]);
                end
            end
            BUS_W16: begin
                if (pix && depth18) begin
                    plan.count   = BEAT_IW'(3);
                    plan.word[0] = on_hi6(value[17:12]);
                    plan.word[1] = on_mid6(value[11:6]);
                    plan.word[2] = on_hi6(value[5:0]);
                end else begin
                    plan.count   = BEAT_IW'(1);
                    plan.word[0] = spread16(reg_word);
                end
            end
            default: begin
                plan.count   = BEAT_IW'(1);
                plan.word[0] = pix ? value : spread16(reg_word);
            end
        endcase
    end

endmodule

// File: rtl/pdw_phase_timer.sv
module pdw_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pdw_write_engine.sv
module pdw_write_engine
    import pdw_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int LOW_CYC   = 2,
    parameter int HIGH_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_data,
    input  logic              req_is_pixel,
    input  logic [DATA_W-1:0] req_value,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_depth18,
    input  logic              cfg_bus6800,
    output logic              bus_cs_n,
    output logic              bus_dc,
    output logic              bus_wr_n,
    output logic              bus_e,
    output logic              bus_rw,
    output logic [DATA_W-1:0] bus_data,
    output logic              done
);

    localparam int MAX_CYC = max3(SETUP_CYC, LOW_CYC, HIGH_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);

    seq_state_e         state_q, state_d;
    logic [BEAT_IW-1:0] beat_q, beat_d;
    wr_req_t            req_q;
    beat_plan_t         plan;
    logic               accept;
    logic               tmr_load, tmr_expired;
    logic [CNT_W-1:0]   tmr_val;
    logic               in_frame, in_beat, strobe;
    logic [DATA_W-1:0]  beat_word;

    assign accept = req_valid && (state_q == ST_IDLE);

    // Request and mode are frozen at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.is_data  <= req_is_data;
            req_q.is_pixel <= req_is_pixel;
            req_q.value    <= req_value;
            req_q.width    <= bus_width_e'(cfg_width);
            req_q.depth18  <= cfg_depth18;
            req_q.bus6800  <= cfg_bus6800;
        end
    end

    pdw_beat_planner u_planner (
        .pix     (req_q.is_data && req_q.is_pixel),
        .width   (req_q.width),
        .depth18 (req_q.depth18),
        .value   (req_q.value),
        .plan    (plan)
    );

    pdw_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        state_d  = state_q;
        beat_d   = beat_q;
        tmr_load = 1'b0;
        tmr_val  = SETUP_LD;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = '0;
                if (accept) state_d = ST_SEL;
            end
            ST_SEL: begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SETUP_LD;
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LOW_LD;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HIGH_LD;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    if (beat_q == BEAT_IW'(plan.count - 1'b1)) begin
                        state_d = ST_FIN;
                    end else begin
                        beat_d   = beat_q + 1'b1;
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        unique case (beat_q)
            BEAT_IW'(0): beat_word = plan.word[0];
            BEAT_IW'(1): beat_word = plan.word[1];
            default:     beat_word = plan.word[2];
        endcase
    end

    assign in_beat  = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign in_frame = in_beat || (state_q == ST_SEL);
    assign strobe   = (state_q == ST_LOW);

    assign req_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_FIN);
    assign bus_cs_n  = !in_frame;
    assign bus_dc    = in_beat && req_q.is_data;
    assign bus_data  = in_beat ? beat_word : '0;
    assign bus_wr_n  = !(strobe && !req_q.bus6800);
    assign bus_e     = strobe && req_q.bus6800;
    assign bus_rw    = !(in_frame && req_q.bus6800);

    a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_n || bus_e) |-> !bus_cs_n);

    a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
        ((!bus_wr_n || bus_e) && $past(!bus_wr_n || bus_e)) |-> $stable(bus_data));

    a_r5_one_strobe_kind: assert property (@(posedge clk) disable iff (rst)
        !(bus_e && !bus_wr_n));

    a_r5_rw_at_write: assert property (@(posedge clk) disable iff (rst)
        bus_e |-> !bus_rw);

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_cs_n && !done));

    a_r3_done_after_cs: assert property (@(posedge clk) disable iff (rst)
        done |-> (bus_cs_n && $past(!bus_cs_n)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_dc_steady: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs_n && $past(!bus_cs_n) && $past(bus_dc)) |-> bus_dc);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> (bus_data == '0 && !bus_dc));

endmodule

// File: tb/pdw_write_engine_tb.sv
module pdw_write_engine_tb;
    import pdw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TB_SETUP   = 2;
    localparam int TB_LOW     = 3;
    localparam int TB_HIGH    = 2;
    localparam int BEAT_LEN   = TB_SETUP + TB_LOW + TB_HIGH;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_data = 1'b0;
    logic        req_is_pixel = 1'b0;
    logic [17:0] req_value = '0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_depth18 = 1'b0;
    logic        cfg_bus6800 = 1'b0;
    logic        bus_cs_n, bus_dc, bus_wr_n, bus_e, bus_rw, done;
    logic [17:0] bus_data;

    pdw_write_engine #(
        .SETUP_CYC (TB_SETUP),
        .LOW_CYC   (TB_LOW),
        .HIGH_CYC  (TB_HIGH)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_is_data  (req_is_data),
        .req_is_pixel (req_is_pixel),
        .req_value    (req_value),
        .cfg_width    (cfg_width),
        .cfg_depth18  (cfg_depth18),
        .cfg_bus6800  (cfg_bus6800),
        .bus_cs_n     (bus_cs_n),
        .bus_dc       (bus_dc),
        .bus_wr_n     (bus_wr_n),
        .bus_e        (bus_e),
        .bus_rw       (bus_rw),
        .bus_data     (bus_data),
        .done         (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [17:0] data;
        logic        dc;
        string       tag;
    } exp_beat_t;

    exp_beat_t exp_beats[$];
    int        exp_len[$];
    string     exp_len_tag[$];

    int   n_checks = 0;
    int   n_fail   = 0;
    logic exp_6800 = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Monitor: samples at the falling edge, pops the scoreboard at each strobe end
    logic        prev_strobe = 1'b0;
    logic        prev_cs_low = 1'b0;
    logic [17:0] prev_data   = '0;
    logic        prev_dc     = 1'b0;
    int          low_cnt     = 0;
    int          cs_cnt      = 0;

    always @(negedge clk) begin
        if (!rst) begin
            logic strobe_now;
            strobe_now = !bus_wr_n || bus_e;
            if (strobe_now) low_cnt++;
            if (prev_strobe && !strobe_now) begin
                check(low_cnt == TB_LOW, "R4", "strobe active width", low_cnt, TB_LOW);
                if (exp_beats.size() == 0) begin
                    check(1'b0, "R2", "unexpected beat", prev_data, 0);
                end else begin
                    exp_beat_t e;
                    e = exp_beats.pop_front();
                    check(prev_data == e.data, e.tag, "beat data", prev_data, e.data);
                    check(prev_dc == e.dc, "R3", "dc level in beat", prev_dc, e.dc);
                end
                low_cnt = 0;
            end
            if (!bus_cs_n) begin
                cs_cnt++;
                if (exp_6800) begin
                    check(!bus_rw && bus_wr_n, "R5", "rw/wr_n in enable style",
                          {bus_rw, bus_wr_n}, 2'b01);
                end else begin
                    check(!bus_e, "R5", "e low in write-strobe style", bus_e, 0);
                end
            end else begin
                check(bus_data == '0, "R12", "data bus idle", bus_data, 0);
            end
            if (prev_cs_low && bus_cs_n) begin
                if (exp_len.size() == 0) begin
                    check(1'b0, "R2", "unexpected transaction", cs_cnt, 0);
                end else begin
                    int    l;
                    string t;
                    l = exp_len.pop_front();
                    t = exp_len_tag.pop_front();
                    check(cs_cnt == l, "R4", {"cs low length ", t}, cs_cnt, l);
                end
                check(done, "R3", "done at cs release", done, 1);
                cs_cnt = 0;
            end
            prev_strobe = strobe_now;
            prev_cs_low = !bus_cs_n;
            prev_data   = bus_data;
            prev_dc     = bus_dc;
        end
    end

    // Driver: computes the expected beats from the requirements and runs one request
    task automatic send(input string tag, input bit is_data, input bit is_pixel,
                        input logic [17:0] v, input logic [1:0] w,
                        input bit d18, input bit m6800);
        logic [17:0] bw[3];
        int          n;
        bit          pix;
        pix = is_data && is_pixel;
        bw[0] = '0; bw[1] = '0; bw[2] = '0;
        case (w)
            2'd0: begin
                if (pix && d18) begin
                    n = 3;
                    bw[0][17:12] = v[17:12];
                    bw[1][17:12] = v[11:6];
                    bw[2][17:12] = v[5:0];
                end else begin
                    n = 2;
                    bw[0][17:10] = v[15:8];
                    bw[1][17:10] = v[7:0];
                end
            end
            2'd1: begin
                n = 2;
                if (pix) begin
                    bw[0][17:9] = v[17:9];
                    bw[1][17:9] = v[8:0];
                end else begin
                    bw[0][17:10] = v[15:8];
                    bw[1][17:10] = v[7:0];
                end
            end
            2'd2: begin
                if (pix && d18) begin
                    n = 3;
                    bw[0][17:12] = v[17:12];
                    bw[1][8:3]   = v[11:6];
                    bw[2][17:12] = v[5:0];
                end else begin
                    n = 1;
                    bw[0][17:10] = v[15:8];
                    bw[0][8:1]   = v[7:0];
                end
            end
            default: begin
                n = 1;
                if (pix) begin
                    bw[0] = v;
                end else begin
                    bw[0][17:10] = v[15:8];
                    bw[0][8:1]   = v[7:0];
                end
            end
        endcase
        for (int i = 0; i < n; i++) begin
            exp_beat_t e;
            e.data = bw[i];
            e.dc   = is_data;
            e.tag  = tag;
            exp_beats.push_back(e);
        end
        exp_len.push_back(1 + n * BEAT_LEN);
        exp_len_tag.push_back(tag);

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_6800     = m6800;
        req_is_data  = is_data;
        req_is_pixel = is_pixel;
        req_value    = v;
        cfg_width    = w;
        cfg_depth18  = d18;
        cfg_bus6800  = m6800;
        req_valid    = 1'b1;
        @(negedge clk);
        check(!req_ready, "R2", "ready low after accept", req_ready, 0);
        // Offer conflicting traffic for the whole busy period
        req_is_data  = !is_data;
        req_is_pixel = !is_pixel;
        req_value    = ~v;
        cfg_width    = ~w;
        cfg_depth18  = !d18;
        cfg_bus6800  = !m6800;
        while (!done) @(negedge clk);
        check(!req_ready, "R2", "ready low in done cycle", req_ready, 0);
        req_valid = 1'b0;
        @(negedge clk);
        check(!done && bus_cs_n, "R3", "done single cycle", {done, bus_cs_n}, 2'b01);
        check(req_ready, "R2", "ready after done", req_ready, 1);
        @(negedge clk);
        check(exp_beats.size() == 0, tag, "beats left over", exp_beats.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        check(req_ready && bus_cs_n && bus_wr_n && !bus_e && bus_rw && !bus_dc && !done,
              "R1", "control lines in reset",
              {req_ready, bus_cs_n, bus_wr_n, bus_e, bus_rw, bus_dc, done}, 7'b1110100);
        check(bus_data == '0, "R1", "data in reset", bus_data, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(req_ready && bus_cs_n && bus_wr_n && !bus_e && !done, "R1", "idle after reset",
              {req_ready, bus_cs_n, bus_wr_n, bus_e, done}, 5'b11100);

        // Write-strobe style
        send("R6",  1'b1, 1'b0, 18'h31234, 2'd0, 1'b0, 1'b0);
        send("R6",  1'b0, 1'b1, 18'h2A5C3, 2'd0, 1'b1, 1'b0);
        send("R6",  1'b1, 1'b1, 18'h3BEEF, 2'd0, 1'b0, 1'b0);
        send("R7",  1'b1, 1'b1, 18'h2D6B5, 2'd0, 1'b1, 1'b0);
        send("R8",  1'b1, 1'b0, 18'h0C35A, 2'd1, 1'b1, 1'b0);
        send("R8",  1'b1, 1'b1, 18'h2B3C7, 2'd1, 1'b0, 1'b0);
        send("R9",  1'b0, 1'b0, 18'h3FFFF, 2'd2, 1'b0, 1'b0);
        send("R9",  1'b1, 1'b1, 18'h1A55A, 2'd2, 1'b0, 1'b0);
        send("R10", 1'b1, 1'b1, 18'h3F03C, 2'd2, 1'b1, 1'b0);
        send("R11", 1'b1, 1'b0, 18'h2C3A5, 2'd3, 1'b1, 1'b0);
        send("R11", 1'b1, 1'b1, 18'h3FFFF, 2'd3, 1'b0, 1'b0);
        send("R12", 1'b1, 1'b1, 18'h00001, 2'd3, 1'b1, 1'b0);
        // Enable style
        send("R5",  1'b1, 1'b1, 18'h15A3C, 2'd0, 1'b1, 1'b1);
        send("R5",  1'b1, 1'b1, 18'h2E71B, 2'd2, 1'b1, 1'b1);
        send("R5",  1'b0, 1'b0, 18'h00A5F, 2'd1, 1'b0, 1'b1);
        send("R5",  1'b1, 1'b1, 18'h24681, 2'd3, 1'b0, 1'b1);
        // Back in write-strobe style right after enable style
        send("R12", 1'b1, 1'b1, 18'h3FFFF, 2'd2, 1'b1, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_len.size() == 0, "R3", "transactions missing", exp_len.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule